// File: doc/BRIEF.md
# USB Pipe Buffer Readiness Controller

This block tracks the one or two buffer planes owned by a single USB device pipe and decides when each plane is handed over. In the receive direction the producer is the bus receiver, which delivers whole packets with a byte count, and a handed-over plane becomes readable by the CPU. In the transmit direction the producer is the CPU or DMA writing one byte per strobe, and a handed-over plane becomes sendable to the host. The consumer drains the oldest ready plane one byte per read strobe, or discards it with an explicit clear.

Two release policies exist. Per-packet mode hands over a plane after every received packet, or once a full maximum-size packet has been written. Continuous mode keeps filling a plane and releases it only when it is full, when a short packet arrives, when an empty packet lands on a plane that already holds data, or when a programmed number of transactions has been received. In the transmit direction a DMA transfer-end pulse can also flush a partly written plane. When the producer's next plane is still occupied, a full flag tells the serial engine to answer the host with NAK.

Top module: `usbpb_ctrl`

## Requirements
- R1: Plane size is 64 × (size code + 1) bytes on a general pipe and always 256 bytes on the control pipe (`cfg_is_ctrl` = 1).
- R2: With `cfg_dbl` = 1 on a general pipe the producer fills plane 0 and plane 1 alternately, bit i of `plane_ready` and `plane_cnt<i>` belong to plane i; the control pipe always uses plane 0 only.
- R3: `cfg_err` is 1 when continuous mode is selected and the plane size is not a whole multiple of `cfg_mps` (or `cfg_mps` is 0); otherwise 0.
- R4: In continuous receive mode a plane becomes ready in the cycle after its stored byte count reaches the plane size, and not earlier.
- R5: In continuous receive mode a packet with 0 < length < `cfg_mps` makes the current plane ready.
- R6: A zero-length packet in continuous mode makes the plane ready only if the plane already holds data; on an empty plane it changes nothing.
- R7: On a general pipe with `cfg_txn_cnt` = N > 0, the N-th packet accepted since the last reload makes the plane ready; the counter reloads on that packet and on `pipe_clr`; the control pipe ignores the counter.
- R8: In transmit direction with `cfg_dmaend_en` = 1 on a general pipe, a `dma_end` pulse makes the current non-full plane ready, even with zero bytes; with the enable low, on the control pipe, or in receive direction the pulse has no effect.
- R9: In per-packet mode every accepted received packet (including zero-length) makes its plane ready, and in transmit direction a plane becomes ready when its written count reaches `cfg_mps`.
- R10: `buf_full` is 1 when the plane the producer would fill next is ready; packets and writes offered while it is 1 are dropped and leave all counts unchanged.
- R11: Each `rd_stb` takes one byte from the oldest ready plane; the strobe that takes its last byte frees it with count 0, `clr_plane` frees it at once with count 0, and both are ignored when no plane is ready.
- R12: Reset and `pipe_clr` free every plane, zero all counts and restart filling and draining at plane 0.
- R13: `cfg_tx` = 0 selects received packets as producer and ignores `wr_stb`; `cfg_tx` = 1 selects `wr_stb` and ignores `rx_pkt_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_is_ctrl | input | 1 | Pipe is the control pipe (fixed 256-byte single plane) |
| cfg_cont | input | 1 | 1 = continuous mode, 0 = per-packet mode |
| cfg_dbl | input | 1 | 1 = two planes |
| cfg_size_code | input | SIZE_W | Plane size code |
| cfg_mps | input | MPS_W | Maximum packet size in bytes |
| cfg_tx | input | 1 | 1 = transmit, 0 = receive |
| cfg_txn_cnt | input | TXN_W | Transactions per plane, 0 = off |
| cfg_dmaend_en | input | 1 | Enables flushing on DMA transfer end |
| pipe_clr | input | 1 | Synchronous clear of the pipe |
| rx_pkt_valid | input | 1 | A received packet ends this cycle |
| rx_pkt_len | input | MPS_W | Byte count of that packet |
| wr_stb | input | 1 | One byte written into the current plane |
| rd_stb | input | 1 | One byte taken from the oldest ready plane |
| clr_plane | input | 1 | Discard the oldest ready plane |
| dma_end | input | 1 | DMA transfer-end pulse |
| plane_ready | output | 2 | Ready flag per plane |
| buf_full | output | 1 | No free plane for the producer (answer NAK) |
| plane_cnt0 | output | CNT_W | Bytes stored in plane 0 |
| plane_cnt1 | output | CNT_W | Bytes stored in plane 1 |
| cfg_err | output | 1 | Continuous-mode size mismatch |

## Verification
In double-buffer operation the consumer may free the last byte of one plane in the very cycle the producer completes the other, so the draining pointer and the filling pointer both move at one edge. The bench provokes this by parking a full plane 0 with one byte left and a half-filled plane 1, then raising the final read strobe together with a packet that fills plane 1. It then judges that plane 0 is free with count 0, plane 1 is ready with the full count, and the full flag is low because the producer has wrapped to the freed plane.

// File: rtl/usbpb_pkg.sv
package usbpb_pkg;
  localparam int UNIT_BYTES = 64;
  localparam int CTRL_BYTES = 256;

  // Bytes in one plane for the given pipe kind and size code.
  function automatic int plane_bytes(input logic is_ctrl, input int code);
    return is_ctrl ? CTRL_BYTES : (code + 1) * UNIT_BYTES;
  endfunction

  // Continuous mode needs a plane that holds a whole number of packets.
  function automatic logic size_mismatch(input logic cont, input int psize, input int mps);
    if (!cont) return 1'b0;
    if (mps == 0) return 1'b1;
    return (psize % mps) != 0;
  endfunction

  function automatic int count_width(input int size_w);
    int top;
    top = (1 << size_w) * UNIT_BYTES;
    if (top < CTRL_BYTES) top = CTRL_BYTES;
    return $clog2(top) + 1;
  endfunction
endpackage

// File: rtl/usbpb_plane.sv
module usbpb_plane #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             add_en,
  input  logic [CNT_W-1:0] add_val,
  input  logic             rel,
  input  logic             take,
  input  logic             drop,
  output logic             ready,
  output logic [CNT_W-1:0] count
);
  logic last_byte;
  assign last_byte = take && (count <= CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready <= 1'b0;
      count <= '0;
    end else if (clr) begin
      ready <= 1'b0;
      count <= '0;
    end else begin
      if (add_en) count <= count + add_val;
      if (rel)    ready <= 1'b1;
      if (drop || last_byte) begin
        ready <= 1'b0;
        count <= '0;
      end else if (take) begin
        count <= count - CNT_W'(1);
      end
    end
  end

  AST_FILL_ONLY_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (add_en || rel) |-> !ready); // R10
  AST_DRAIN_ONLY_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (take || drop) |-> ready); // R11
  AST_FREE_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    (drop && !clr) |=> (!ready && count == '0)); // R11
endmodule

// File: rtl/usbpb_txn.sv
module usbpb_txn #(
  parameter int TXN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reload,
  input  logic             pkt,
  input  logic             en,
  input  logic [TXN_W-1:0] cfg_n,
  output logic             last
);
  logic [TXN_W-1:0] left;
  logic [TXN_W-1:0] eff;

  // A zero count after reset means "not loaded yet": use the programmed value.
  assign eff  = (left == '0) ? cfg_n : left;
  assign last = en && (eff == TXN_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           left <= '0;
    else if (reload)      left <= cfg_n;
    else if (pkt && en)   left <= last ? cfg_n : eff - TXN_W'(1);
  end

  AST_TXN_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt && last && !reload) |=> (left == $past(cfg_n))); // R7
endmodule

// File: rtl/usbpb_release.sv
module usbpb_release #(
  parameter int CNT_W = 11,
  parameter int MPS_W = 11
) (
  input  logic             cont,
  input  logic             rx_acc,
  input  logic             wr_acc,
  input  logic             dma_acc,
  input  logic             txn_last,
  input  logic [MPS_W-1:0] len,
  input  logic [MPS_W-1:0] mps,
  input  logic [CNT_W-1:0] cur,
  input  logic [CNT_W-1:0] psize,
  output logic [CNT_W-1:0] add_val,
  output logic [CNT_W:0]   new_cnt,
  output logic             rel
);
  localparam int NW = CNT_W + 1;

  logic hit_size, hit_mps, short_pkt, zlp_data, rx_rel, wr_rel;

  assign add_val   = rx_acc ? CNT_W'(len) : CNT_W'(wr_acc);
  assign new_cnt   = NW'(cur) + NW'(add_val);
  assign hit_size  = new_cnt == NW'(psize);
  assign hit_mps   = new_cnt == NW'(mps);
  assign short_pkt = (len != '0) && (len < mps);
  assign zlp_data  = (len == '0) && (cur != '0);

  assign rx_rel = rx_acc && (!cont || hit_size || short_pkt || zlp_data || txn_last);
  assign wr_rel = wr_acc && (hit_size || (!cont && hit_mps));
  assign rel    = rx_rel || wr_rel || dma_acc;
endmodule

// File: rtl/usbpb_ctrl.sv
module usbpb_ctrl
  import usbpb_pkg::*;
#(
  parameter int SIZE_W = 4,
  parameter int MPS_W  = 11,
  parameter int TXN_W  = 8,
  localparam int CNT_W = count_width(SIZE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_is_ctrl,
  input  logic              cfg_cont,
  input  logic              cfg_dbl,
  input  logic [SIZE_W-1:0] cfg_size_code,
  input  logic [MPS_W-1:0]  cfg_mps,
  input  logic              cfg_tx,
  input  logic [TXN_W-1:0]  cfg_txn_cnt,
  input  logic              cfg_dmaend_en,
  input  logic              pipe_clr,
  input  logic              rx_pkt_valid,
  input  logic [MPS_W-1:0]  rx_pkt_len,
  input  logic              wr_stb,
  input  logic              rd_stb,
  input  logic              clr_plane,
  input  logic              dma_end,
  output logic [1:0]        plane_ready,
  output logic              buf_full,
  output logic [CNT_W-1:0]  plane_cnt0,
  output logic [CNT_W-1:0]  plane_cnt1,
  output logic              cfg_err
);
  localparam int NW = CNT_W + 1;

  logic             wp, rp, dbl;
  logic [1:0]       rdy;
  logic [CNT_W-1:0] cnt [2];
  logic [CNT_W-1:0] psize, cur, add_val;
  logic [CNT_W:0]   new_cnt;
  logic             rx_acc, wr_acc, dma_acc, add_en, prod_rel, txn_last, txn_en;
  logic             take, drop, cons_free;

  assign psize   = CNT_W'(plane_bytes(cfg_is_ctrl, int'(cfg_size_code)));
  assign cfg_err = size_mismatch(cfg_cont, int'(psize), int'(cfg_mps));
  assign dbl     = cfg_dbl && !cfg_is_ctrl;

  // Producer side: the plane at wp.
  assign buf_full = rdy[wp];
  assign cur      = cnt[wp];
  assign rx_acc   = rx_pkt_valid && !cfg_tx && !buf_full && !pipe_clr;
  assign wr_acc   = wr_stb && cfg_tx && !buf_full && !pipe_clr;
  assign dma_acc  = dma_end && cfg_tx && cfg_dmaend_en && !cfg_is_ctrl && !buf_full && !pipe_clr;
  assign add_en   = rx_acc || wr_acc;
  assign txn_en   = !cfg_is_ctrl && (cfg_txn_cnt != '0);

  usbpb_txn #(.TXN_W(TXN_W)) txn_i (
    .clk(clk), .rst_n(rst_n), .reload(pipe_clr), .pkt(rx_acc), .en(txn_en),
    .cfg_n(cfg_txn_cnt), .last(txn_last)
  );

  usbpb_release #(.CNT_W(CNT_W), .MPS_W(MPS_W)) rel_i (
    .cont(cfg_cont), .rx_acc(rx_acc), .wr_acc(wr_acc), .dma_acc(dma_acc),
    .txn_last(txn_last), .len(rx_pkt_len), .mps(cfg_mps), .cur(cur), .psize(psize),
    .add_val(add_val), .new_cnt(new_cnt), .rel(prod_rel)
  );

  // Consumer side: the plane at rp.
  assign drop      = clr_plane && rdy[rp] && !pipe_clr;
  assign take      = rd_stb && !clr_plane && rdy[rp] && !pipe_clr;
  assign cons_free = drop || (take && cnt[rp] <= CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= 1'b0;
      rp <= 1'b0;
    end else if (pipe_clr) begin
      wp <= 1'b0;
      rp <= 1'b0;
    end else if (dbl) begin
      if (prod_rel)  wp <= !wp;
      if (cons_free) rp <= !rp;
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_plane
    usbpb_plane #(.CNT_W(CNT_W)) plane_i (
      .clk(clk), .rst_n(rst_n), .clr(pipe_clr),
      .add_en(add_en && (wp == 1'(g))), .add_val(add_val),
      .rel(prod_rel && (wp == 1'(g))),
      .take(take && (rp == 1'(g))), .drop(drop && (rp == 1'(g))),
      .ready(rdy[g]), .count(cnt[g])
    );
  end

  assign plane_ready = rdy;
  assign plane_cnt0  = cnt[0];
  assign plane_cnt1  = cnt[1];

  AST_FILL_TO_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_acc && cfg_cont && new_cnt == NW'(psize)) |=> plane_ready[$past(wp)]); // R4
  AST_SHORT_PKT: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_acc && rx_pkt_len != '0 && rx_pkt_len < cfg_mps) |=> plane_ready[$past(wp)]); // R5
  AST_ZLP_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_acc && cfg_cont && rx_pkt_len == '0 && cur == '0 && !txn_last)
      |=> !plane_ready[$past(wp)]); // R6
  AST_DMA_END_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_end && cfg_tx && cfg_dmaend_en && !cfg_is_ctrl && !buf_full && !pipe_clr)
      |=> plane_ready[$past(wp)]); // R8
  AST_CTRL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_is_ctrl |=> (cfg_is_ctrl ? !plane_ready[1] || $past(plane_ready[1]) : 1'b1)); // R2
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    pipe_clr |=> (plane_ready == 2'b00 && plane_cnt0 == '0 && plane_cnt1 == '0)); // R12
endmodule

// File: tb/usbpb_ctrl_tb.sv
module usbpb_ctrl_tb_top;
  localparam int SIZE_W = 4;
  localparam int MPS_W  = 11;
  localparam int TXN_W  = 8;
  localparam int CNT_W  = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_is_ctrl = 0, cfg_cont = 0, cfg_dbl = 0, cfg_tx = 0, cfg_dmaend_en = 0;
  logic [SIZE_W-1:0] cfg_size_code = '0;
  logic [MPS_W-1:0]  cfg_mps = '0;
  logic [TXN_W-1:0]  cfg_txn_cnt = '0;
  logic pipe_clr = 0, rx_pkt_valid = 0, wr_stb = 0, rd_stb = 0, clr_plane = 0, dma_end = 0;
  logic [MPS_W-1:0] rx_pkt_len = '0;
  logic [1:0] plane_ready;
  logic buf_full, cfg_err;
  logic [CNT_W-1:0] plane_cnt0, plane_cnt1;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = !clk;

  usbpb_ctrl #(.SIZE_W(SIZE_W), .MPS_W(MPS_W), .TXN_W(TXN_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_is_ctrl(cfg_is_ctrl), .cfg_cont(cfg_cont),
    .cfg_dbl(cfg_dbl), .cfg_size_code(cfg_size_code), .cfg_mps(cfg_mps),
    .cfg_tx(cfg_tx), .cfg_txn_cnt(cfg_txn_cnt), .cfg_dmaend_en(cfg_dmaend_en),
    .pipe_clr(pipe_clr), .rx_pkt_valid(rx_pkt_valid), .rx_pkt_len(rx_pkt_len),
    .wr_stb(wr_stb), .rd_stb(rd_stb), .clr_plane(clr_plane), .dma_end(dma_end),
    .plane_ready(plane_ready), .buf_full(buf_full), .plane_cnt0(plane_cnt0),
    .plane_cnt1(plane_cnt1), .cfg_err(cfg_err)
  );

  // Independent size model: a shift plus one unit, control pipe pinned.
  function automatic int exp_size(input bit ctrl, input int code);
    if (ctrl) return 256;
    return (code << 6) + 64;
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic setup(input bit ctrl, input bit cont, input bit dbl, input int code,
                       input int mps, input bit tx, input int txn, input bit den);
    @(negedge clk);
    cfg_is_ctrl = ctrl; cfg_cont = cont; cfg_dbl = dbl; cfg_size_code = SIZE_W'(code);
    cfg_mps = MPS_W'(mps); cfg_tx = tx; cfg_txn_cnt = TXN_W'(txn); cfg_dmaend_en = den;
    pipe_clr = 1;
    @(negedge clk);
    pipe_clr = 0;
  endtask

  task automatic rx(input int len);
    @(negedge clk);
    rx_pkt_valid = 1; rx_pkt_len = MPS_W'(len);
    @(negedge clk);
    rx_pkt_valid = 0;
  endtask

  task automatic wr(input int n);
    @(negedge clk);
    wr_stb = 1;
    repeat (n - 1) @(negedge clk);
    @(negedge clk);
    wr_stb = 0;
  endtask

  task automatic rd(input int n);
    @(negedge clk);
    rd_stb = 1;
    repeat (n - 1) @(negedge clk);
    @(negedge clk);
    rd_stb = 0;
  endtask

  task automatic pulse_clr_plane();
    @(negedge clk); clr_plane = 1;
    @(negedge clk); clr_plane = 0;
  endtask

  task automatic pulse_dma_end();
    @(negedge clk); dma_end = 1;
    @(negedge clk); dma_end = 0;
  endtask

  task automatic t_reset();
    check("R12", "reset ready", plane_ready, 0);
    check("R12", "reset full", buf_full, 0);
    check("R12", "reset cnt0", plane_cnt0, 0);
  endtask

  task automatic t_fill_general();
    setup(0, 1, 0, 1, 64, 0, 0, 0);
    rx(64);
    check("R4", "half plane not ready", plane_ready, 0);
    check("R4", "half count", plane_cnt0, 64);
    rd(3);
    check("R11", "read on non-ready ignored", plane_cnt0, 64);
    rx(64);
    check("R1", "ready at 128", plane_ready, 1);
    check("R1", "count at size", plane_cnt0, exp_size(0, 1));
    check("R10", "full", buf_full, 1);
    rx(64);
    check("R10", "packet while full dropped", plane_cnt0, 128);
    rd(127);
    check("R11", "one byte left", plane_cnt0, 1);
    check("R11", "still ready", plane_ready, 1);
    rd(1);
    check("R11", "freed after last byte", plane_ready, 0);
    check("R11", "count zero", plane_cnt0, 0);
    check("R10", "full low", buf_full, 0);
  endtask

  task automatic t_ctrl_pipe();
    setup(1, 1, 1, 0, 64, 0, 3, 0);
    rx(64); rx(64); rx(64);
    check("R7", "control ignores txn counter", plane_ready, 0);
    check("R1", "control count 192", plane_cnt0, 192);
    rx(64);
    check("R1", "control ready at 256", plane_ready, 1);
    check("R1", "control count", plane_cnt0, exp_size(1, 0));
    check("R2", "control single plane full", buf_full, 1);
    rx(32);
    check("R2", "plane1 unused", plane_cnt1, 0);
    pulse_clr_plane();
    check("R11", "clear frees", plane_ready, 0);
    check("R11", "clear zeroes", plane_cnt0, 0);
  endtask

  task automatic t_short_zlp();
    setup(0, 1, 0, 1, 64, 0, 0, 0);
    rx(20);
    check("R5", "short packet ready", plane_ready, 1);
    check("R5", "short count", plane_cnt0, 20);
    pulse_clr_plane();
    rx(0);
    check("R6", "zlp on empty not ready", plane_ready, 0);
    check("R6", "zlp on empty count", plane_cnt0, 0);
    rx(64);
    check("R6", "full packet holds", plane_ready, 0);
    rx(0);
    check("R6", "zlp on data ready", plane_ready, 1);
    check("R6", "zlp on data count", plane_cnt0, 64);
  endtask

  task automatic t_txn();
    setup(0, 1, 0, 3, 64, 0, 3, 0);
    rx(64); rx(64);
    check("R7", "two of three", plane_ready, 0);
    rx(64);
    check("R7", "third releases", plane_ready, 1);
    check("R7", "txn count", plane_cnt0, 192);
    pulse_clr_plane();
    rx(64); rx(64);
    check("R7", "reloaded after expiry", plane_ready, 0);
    rx(64);
    check("R7", "second round releases", plane_ready, 1);
    pulse_clr_plane();
    rx(64);
    @(negedge clk); pipe_clr = 1;
    @(negedge clk); pipe_clr = 0;
    rx(64); rx(64);
    check("R7", "reloaded by pipe clear", plane_ready, 0);
    rx(64);
    check("R7", "release after clear reload", plane_ready, 1);
  endtask

  task automatic t_double();
    setup(0, 1, 1, 0, 64, 0, 0, 0);
    rx(64);
    check("R2", "plane0 ready", plane_ready, 1);
    check("R10", "one plane free", buf_full, 0);
    rx(64);
    check("R2", "both ready", plane_ready, 3);
    check("R10", "full with two", buf_full, 1);
    rx(10);
    check("R10", "dropped cnt0", plane_cnt0, 64);
    check("R10", "dropped cnt1", plane_cnt1, 64);
    rd(64);
    check("R11", "plane0 drained", plane_ready, 2);
    check("R10", "plane0 free again", buf_full, 0);
    rx(32);
    check("R2", "wrapped to plane0", plane_cnt0, 32);
    check("R2", "both ready again", plane_ready, 3);
  endtask

  task automatic t_overlap();
    setup(0, 1, 1, 1, 64, 0, 0, 0);
    rx(64); rx(64); rx(64);
    rd(127);
    check("R2", "overlap setup cnt1", plane_cnt1, 64);
    @(negedge clk);
    rd_stb = 1; rx_pkt_valid = 1; rx_pkt_len = MPS_W'(64);
    @(negedge clk);
    rd_stb = 0; rx_pkt_valid = 0;
    check("R11", "overlap plane0 freed", plane_cnt0, 0);
    check("R4", "overlap plane1 full", plane_cnt1, 128);
    check("R2", "overlap ready", plane_ready, 2);
    check("R10", "overlap not full", buf_full, 0);
  endtask

  task automatic t_dma();
    setup(0, 1, 0, 1, 64, 1, 0, 1);
    wr(10);
    check("R8", "partial not ready", plane_ready, 0);
    check("R8", "partial count", plane_cnt0, 10);
    pulse_dma_end();
    check("R8", "dma end flushes", plane_ready, 1);
    check("R8", "flushed count", plane_cnt0, 10);
    pulse_clr_plane();
    pulse_dma_end();
    check("R8", "zero byte flush", plane_ready, 1);
    check("R8", "zero byte count", plane_cnt0, 0);
    setup(0, 1, 0, 1, 64, 1, 0, 0);
    wr(5);
    pulse_dma_end();
    check("R8", "disabled ignores", plane_ready, 0);
    setup(1, 1, 0, 0, 64, 1, 0, 1);
    pulse_dma_end();
    check("R8", "control ignores", plane_ready, 0);
    setup(0, 1, 0, 1, 64, 0, 0, 1);
    pulse_dma_end();
    check("R8", "receive ignores", plane_ready, 0);
  endtask

  task automatic t_percket();
    setup(0, 0, 0, 1, 64, 0, 0, 0);
    rx(64);
    check("R9", "rx per packet", plane_ready, 1);
    check("R9", "rx count", plane_cnt0, 64);
    setup(0, 0, 0, 1, 64, 0, 0, 0);
    rx(0);
    check("R9", "zlp per packet", plane_ready, 1);
    setup(0, 0, 0, 1, 64, 1, 0, 0);
    wr(63);
    check("R9", "tx below mps", plane_ready, 0);
    wr(1);
    check("R9", "tx at mps", plane_ready, 1);
    check("R9", "tx count", plane_cnt0, 64);
  endtask

  task automatic t_cfg_err();
    setup(0, 1, 0, 0, 48, 0, 0, 0);
    check("R3", "64 by 48 continuous", cfg_err, 1);
    setup(0, 1, 0, 0, 32, 0, 0, 0);
    check("R3", "64 by 32 continuous", cfg_err, 0);
    setup(0, 0, 0, 0, 48, 0, 0, 0);
    check("R3", "per-packet no error", cfg_err, 0);
    setup(0, 1, 0, 2, 0, 0, 0, 0);
    check("R3", "zero mps", cfg_err, 1);
  endtask

  task automatic t_direction_clear();
    setup(0, 1, 0, 1, 64, 0, 0, 0);
    wr(5);
    check("R13", "write ignored in receive", plane_cnt0, 0);
    setup(0, 1, 0, 1, 64, 1, 0, 0);
    rx(20);
    check("R13", "packet ignored in transmit", plane_cnt0, 0);
    check("R13", "packet ignored ready", plane_ready, 0);
    setup(0, 1, 1, 0, 64, 0, 0, 0);
    rx(64); rx(20);
    @(negedge clk); pipe_clr = 1;
    @(negedge clk); pipe_clr = 0;
    check("R12", "clear ready", plane_ready, 0);
    check("R12", "clear cnt1", plane_cnt1, 0);
    rx(30);
    check("R12", "restart at plane0", plane_cnt0, 30);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_fill_general();
    t_ctrl_pipe();
    t_short_zlp();
    t_txn();
    t_double();
    t_overlap();
    t_dma();
    t_percket();
    t_cfg_err();
    t_direction_clear();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule